// File: doc/BRIEF.md
# Access-Stepped Vector Microkernel Unit

This block is a small processing unit placed next to one DRAM bank. A host first writes a short program (up to 32 instruction words) into a local command store while the unit is disabled. Once the unit is enabled, each memory access that the host sends to the bank executes exactly one instruction. That instruction can combine the 256-bit bank data word with entries of a 16-entry wide vector register file and an 8-entry scalar register file. The arithmetic is done by sixteen independent FP16 lanes.

Lane arithmetic rounds to nearest, ties to even. Subnormal inputs and subnormal results are flushed to zero, and results too large for the format become infinity. Each vector result is written into the register file and also presented on the write-back port one cycle after the access that produced it.

An address-aligned flag in an arithmetic instruction makes the unit take its register indices from the access address instead of from the instruction word. The host's memory controller may reorder accesses. With the flag set, each piece of data still meets the register that belongs to its address. A counted jump allows loops inside the 32-word store. An exit instruction rewinds the program and raises a completion flag.

Top module: `pim_microkernel_seq`

## Requirements
- R1: After reset the program counter is 0, the completion flag is 0 and the write-back valid output is 0.
- R2: When the unit is enabled, an access executes the instruction at the program counter. Every non-control instruction then increments the program counter by one. An access while the unit is disabled, and any cycle without an access, leaves the program counter unchanged and gives no write-back pulse.
- R3: A load write stores a 32-bit instruction at the given command-store slot only while the unit is disabled; load writes while enabled are dropped. Instruction fields: opcode [31:28], destination [27:24], source A [23:20], source B [19:16], address-aligned flag [15], A-from-bank flag [14], B-from-scalar flag [13], jump count [12:8], jump target [4:0]. Opcodes: 0 no-op, 1 add, 2 multiply, 3 move, 4 scalar load, 6 jump, 7 exit (others act as no-op).
- R4: Add writes the lane-wise FP16 sum of operands A and B to the vector register named by the destination field. The result appears on the write-back data with write-back valid high in the cycle after the access.
- R5: Multiply does the same with the lane-wise FP16 product.
- R6: Operand A is the bank data word when the A-from-bank flag is 1, otherwise vector register source A. Operand B is scalar register source B[2:0] repeated across all lanes when the B-from-scalar flag is 1, otherwise vector register source B. Scalar load copies lane 0 (bits 15:0) of the bank data into scalar register destination[2:0]. Move writes operand A.
- R7: When the address-aligned flag of an add, multiply or move is set, the destination and both vector source indices are {row[0], col[2:0]}, and the scalar index is col[5:3]. The instruction's index fields are ignored.
- R8: A jump with count N sends the program counter to the target on its first N executions and falls through to the next slot on the following one, after which the count is rearmed.
- R9: Exit sets the program counter to 0 and sets the completion flag. The completion flag stays set until reset or an accepted load write.
- R10: Lanes flush subnormal inputs and subnormal results to zero, round to nearest even, and give infinity on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Unit enabled; when low, loads are accepted and accesses are ignored |
| acc_valid | input | 1 | Host access to the bank in this cycle |
| acc_row | input | 14 | Row address of the access |
| acc_col | input | 6 | Column address of the access |
| bank_data | input | 256 | Bank data word of the access, 16 FP16 lanes |
| ld_we | input | 1 | Program load write strobe |
| ld_addr | input | 5 | Command-store slot to write |
| ld_data | input | 32 | Instruction word to write |
| wb_valid | output | 1 | Write-back data valid, one cycle after an access producing a vector |
| wb_data | output | 256 | Last vector result |
| pc | output | 5 | Current program counter |
| done | output | 1 | Completion flag raised by exit |

## Verification
The hardest case to reach is the address-aligned path. Its effect only shows when the register index taken from the address differs from the index in the instruction word. To make it visible, the instruction fields are left at zero while the accesses carry row bit 1 and column values whose low and middle bit groups name vector register 13 and scalar register 5. The result can only be right if both indices came from the address. The counted jump is followed access by access through its two taken passes and the fall-through. Rounding ties and flush-to-zero are driven by operand pairs chosen so that their exact results sit on a halfway point, below the normal range, or beyond the largest finite value.

// File: rtl/pim_seq_pkg.sv
package pim_seq_pkg;

    localparam int LANE_W = 16;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_MUL  = 4'd2,
        OP_MOV  = 4'd3,
        OP_SLD  = 4'd4,
        OP_JUMP = 4'd6,
        OP_EXIT = 4'd7
    } opcode_e;

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  dst;
        logic [3:0]  src_a;
        logic [3:0]  src_b;
        logic        aam;
        logic        a_bank;
        logic        b_scalar;
        logic [12:0] imm;
    } instr_t;

    // FP16 multiply, round to nearest even, flush to zero
    function automatic logic [15:0] fp16_mul(input logic [15:0] a, input logic [15:0] b);
        logic        s;
        logic [4:0]  ea, eb;
        logic [21:0] p;
        logic [11:0] m;
        logic        g, st;
        int          e;
        s  = a[15] ^ b[15];
        ea = a[14:10];
        eb = b[14:10];
        if ((ea == 5'h1f && a[9:0] != 0) || (eb == 5'h1f && b[9:0] != 0)) return 16'h7e00;
        if (ea == 5'h1f || eb == 5'h1f) begin
            if (ea == 5'h0 || eb == 5'h0) return 16'h7e00;
            return {s, 5'h1f, 10'h0};
        end
        if (ea == 5'h0 || eb == 5'h0) return {s, 15'h0};
        p = {11'h0, 1'b1, a[9:0]} * {11'h0, 1'b1, b[9:0]};
        e = int'(ea) + int'(eb) - 15;
        if (p[21]) begin
            m = {1'b0, p[21:11]}; g = p[10]; st = |p[9:0]; e = e + 1;
        end else begin
            m = {1'b0, p[20:10]}; g = p[9];  st = |p[8:0];
        end
        if (g && (st || m[0])) m = m + 12'd1;
        if (m[11]) begin m = m >> 1; e = e + 1; end
        if (e >= 31) return {s, 5'h1f, 10'h0};
        if (e <= 0)  return {s, 15'h0};
        return {s, 5'(e), m[9:0]};
    endfunction

    // FP16 add, round to nearest even, flush to zero
    function automatic logic [15:0] fp16_add(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] x, y;
        logic [13:0] mx, my;
        logic [14:0] r;
        logic [11:0] m;
        logic        g, st;
        int          e, d;
        if ((a[14:10] == 5'h1f && a[9:0] != 0) || (b[14:10] == 5'h1f && b[9:0] != 0)) return 16'h7e00;
        if (a[14:10] == 5'h1f && b[14:10] == 5'h1f && a[15] != b[15]) return 16'h7e00;
        if (a[14:10] == 5'h1f) return a;
        if (b[14:10] == 5'h1f) return b;
        if (a[14:10] == 5'h0 && b[14:10] == 5'h0) return {a[15] & b[15], 15'h0};
        if (a[14:10] == 5'h0) return b;
        if (b[14:10] == 5'h0) return a;
        if (b[14:0] > a[14:0]) begin x = b; y = a; end else begin x = a; y = b; end
        e  = int'(x[14:10]);
        d  = e - int'(y[14:10]);
        mx = {1'b1, x[9:0], 3'b000};
        my = {1'b1, y[9:0], 3'b000};
        if (d >= 14) begin
            my = 14'd1;
        end else begin
            st = |(my & ((14'd1 << d) - 14'd1));
            my = my >> d;
            my[0] = my[0] | st;
        end
        if (x[15] == y[15]) begin
            r = {1'b0, mx} + {1'b0, my};
            if (r[14]) begin
                st = r[0];
                r  = r >> 1;
                r[0] = r[0] | st;
                e  = e + 1;
            end
        end else begin
            r = {1'b0, mx} - {1'b0, my};
            if (r == 15'h0) return 16'h0000;
            for (int i = 0; i < 14; i++) begin
                if (!r[13]) begin r = r << 1; e = e - 1; end
            end
        end
        m  = {1'b0, r[13:3]};
        g  = r[2];
        st = |r[1:0];
        if (g && (st || m[0])) m = m + 12'd1;
        if (m[11]) begin m = m >> 1; e = e + 1; end
        if (e >= 31) return {x[15], 5'h1f, 10'h0};
        if (e <= 0)  return {x[15], 15'h0};
        return {x[15], 5'(e), m[9:0]};
    endfunction

endpackage

// File: rtl/pim_cmd_store.sv
module pim_cmd_store #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data
);
    logic [31:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/pim_vec_rf.sv
module pim_vec_rf #(
    parameter int DEPTH = 16,
    parameter int W     = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/pim_simd_fpu.sv
module pim_simd_fpu
    import pim_seq_pkg::*;
#(
    parameter int LANES = 16,
    localparam int VW = LANES * LANE_W
) (
    input  logic          use_mul,
    input  logic [VW-1:0] op_a,
    input  logic [VW-1:0] op_b,
    output logic [VW-1:0] result
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] sum_w, prod_w;
        assign sum_w  = fp16_add(op_a[i*LANE_W +: LANE_W], op_b[i*LANE_W +: LANE_W]);
        assign prod_w = fp16_mul(op_a[i*LANE_W +: LANE_W], op_b[i*LANE_W +: LANE_W]);
        assign result[i*LANE_W +: LANE_W] = use_mul ? prod_w : sum_w;
    end
endmodule

// File: rtl/pim_microkernel_seq.sv
module pim_microkernel_seq
    import pim_seq_pkg::*;
#(
    parameter int LANES     = 16,
    parameter int CRF_DEPTH = 32,
    parameter int GRF_DEPTH = 16,
    parameter int SRF_DEPTH = 8,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 6,
    parameter int LOOP_W    = 5,
    localparam int VEC_W  = LANES * LANE_W,
    localparam int PC_W   = $clog2(CRF_DEPTH),
    localparam int GRF_AW = $clog2(GRF_DEPTH),
    localparam int SRF_AW = $clog2(SRF_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             acc_valid,
    input  logic [ROW_W-1:0] acc_row,
    input  logic [COL_W-1:0] acc_col,
    input  logic [VEC_W-1:0] bank_data,
    input  logic             ld_we,
    input  logic [PC_W-1:0]  ld_addr,
    input  logic [31:0]      ld_data,
    output logic             wb_valid,
    output logic [VEC_W-1:0] wb_data,
    output logic [PC_W-1:0]  pc,
    output logic             done
);
    typedef struct packed {
        logic [PC_W-1:0]                   pc;
        logic                              done;
        logic                              armed;
        logic [LOOP_W-1:0]                 loop_left;
        logic                              wb_valid;
        logic [VEC_W-1:0]                  wb_data;
        logic [SRF_DEPTH-1:0][LANE_W-1:0]  srf;
    } state_t;

    state_t st_q, st_d;

    instr_t              instr;
    logic [31:0]         instr_raw;
    logic                fire, load_ok, grf_we, aligned;
    logic [GRF_AW-1:0]   aam_gidx, dst_idx, ra_idx, rb_idx;
    logic [SRF_AW-1:0]   aam_sidx, s_idx;
    logic [VEC_W-1:0]    grf_a, grf_b, opnd_a, opnd_b, fpu_y, wr_vec;
    logic [LOOP_W-1:0]   jump_left;
    logic                unused_bits;

    assign fire    = en && acc_valid;
    assign load_ok = ld_we && !en;
    assign instr   = instr_t'(instr_raw);

    pim_cmd_store #(.DEPTH(CRF_DEPTH)) u_cmd (
        .clk(clk), .wr_en(load_ok), .wr_addr(ld_addr), .wr_data(ld_data),
        .rd_addr(st_q.pc), .rd_data(instr_raw)
    );

    // index selection: address-aligned mode overrides the instruction fields
    assign aligned  = instr.aam && (instr.op == OP_ADD || instr.op == OP_MUL || instr.op == OP_MOV);
    assign aam_gidx = {acc_row[0], acc_col[GRF_AW-2:0]};
    assign aam_sidx = acc_col[GRF_AW-1 +: SRF_AW];
    assign dst_idx  = aligned ? aam_gidx : instr.dst[GRF_AW-1:0];
    assign ra_idx   = aligned ? aam_gidx : instr.src_a[GRF_AW-1:0];
    assign rb_idx   = aligned ? aam_gidx : instr.src_b[GRF_AW-1:0];
    assign s_idx    = aligned ? aam_sidx : instr.src_b[SRF_AW-1:0];

    pim_vec_rf #(.DEPTH(GRF_DEPTH), .W(VEC_W)) u_grf (
        .clk(clk), .we(grf_we), .waddr(dst_idx), .wdata(wr_vec),
        .raddr_a(ra_idx), .raddr_b(rb_idx), .rdata_a(grf_a), .rdata_b(grf_b)
    );

    assign opnd_a = instr.a_bank   ? bank_data : grf_a;
    assign opnd_b = instr.b_scalar ? {LANES{st_q.srf[s_idx]}} : grf_b;

    pim_simd_fpu #(.LANES(LANES)) u_fpu (
        .use_mul(instr.op == OP_MUL), .op_a(opnd_a), .op_b(opnd_b), .result(fpu_y)
    );

    assign wr_vec    = (instr.op == OP_MOV) ? opnd_a : fpu_y;
    assign grf_we    = fire && (instr.op == OP_ADD || instr.op == OP_MUL || instr.op == OP_MOV);
    assign jump_left = st_q.armed ? st_q.loop_left : instr.imm[8 +: LOOP_W];

    always_comb begin
        st_d          = st_q;
        st_d.wb_valid = grf_we;
        if (grf_we) st_d.wb_data = wr_vec;
        if (load_ok) begin
            st_d.done  = 1'b0;
            st_d.armed = 1'b0;
        end
        if (fire) begin
            st_d.pc = st_q.pc + PC_W'(1);
            case (instr.op)
                OP_SLD: st_d.srf[instr.dst[SRF_AW-1:0]] = bank_data[LANE_W-1:0];
                OP_JUMP: begin
                    if (jump_left != '0) begin
                        st_d.pc        = instr.imm[PC_W-1:0];
                        st_d.loop_left = jump_left - LOOP_W'(1);
                        st_d.armed     = 1'b1;
                    end else begin
                        st_d.armed     = 1'b0;
                    end
                end
                OP_EXIT: begin
                    st_d.pc    = '0;
                    st_d.done  = 1'b1;
                    st_d.armed = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wb_valid = st_q.wb_valid;
    assign wb_data  = st_q.wb_data;
    assign pc       = st_q.pc;
    assign done     = st_q.done;

    assign unused_bits = ^{acc_row, acc_col, instr.imm, instr.dst, instr.src_a, instr.src_b};
endmodule

// File: rtl/pim_microkernel_seq_checks.sv
module pim_microkernel_seq_checks #(
    parameter int PC_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic            acc_valid,
    input logic            ld_we,
    input logic            wb_valid,
    input logic            done,
    input logic [PC_W-1:0] pc
);
    // R2: without an enabled access the program counter holds
    assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && acc_valid) |=> $stable(pc));

    // R2: no write-back pulse without an enabled access
    assert_no_stray_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && acc_valid) |=> !wb_valid);

    // R9: completion only follows an executed access
    assert_done_from_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(en && acc_valid));

    // R9: completion leaves the program rewound
    assert_done_rewinds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> pc == '0);

    // R3: an accepted load clears completion
    assert_load_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we && !en) |=> !done);
endmodule

bind pim_microkernel_seq pim_microkernel_seq_checks #(.PC_W(PC_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .en(en), .acc_valid(acc_valid), .ld_we(ld_we),
    .wb_valid(wb_valid), .done(done), .pc(pc)
);

// File: tb/pim_microkernel_seq_bench.sv
module pim_microkernel_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int VW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          acc_valid = 1'b0;
    logic [13:0]   acc_row = '0;
    logic [5:0]    acc_col = '0;
    logic [VW-1:0] bank_data = '0;
    logic          ld_we = 1'b0;
    logic [4:0]    ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic          wb_valid;
    logic [VW-1:0] wb_data;
    logic [4:0]    pc;
    logic          done;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pim_microkernel_seq u_pim_microkernel_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .acc_valid(acc_valid),
        .acc_row(acc_row), .acc_col(acc_col), .bank_data(bank_data),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .wb_valid(wb_valid), .wb_data(wb_data), .pc(pc), .done(done)
    );

    // {kind(1=add,2=mul), a, b, expected}
    localparam logic [63:0] VECS [12] = '{
        {16'd1, 16'h3c00, 16'h4000, 16'h4200},
        {16'd1, 16'h3c00, 16'hbc00, 16'h0000},
        {16'd1, 16'h3c00, 16'h1000, 16'h3c00},
        {16'd1, 16'h3c00, 16'h1200, 16'h3c01},
        {16'd1, 16'h7bff, 16'h7bff, 16'h7c00},
        {16'd1, 16'h0001, 16'h0001, 16'h0000},
        {16'd1, 16'h4200, 16'hbc00, 16'h4000},
        {16'd2, 16'h3e00, 16'h4000, 16'h4200},
        {16'd2, 16'h0400, 16'h3800, 16'h0000},
        {16'd2, 16'h7bff, 16'h4000, 16'h7c00},
        {16'd2, 16'hc000, 16'h4200, 16'hc600},
        {16'd2, 16'h3c01, 16'h3c01, 16'h3c02}
    };

    function automatic logic [VW-1:0] bcast(input logic [15:0] h);
        return {16{h}};
    endfunction

    task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic access(input logic [13:0] r, input logic [5:0] c, input logic [VW-1:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_row = r; acc_col = c; bank_data = d;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pc", VW'(pc), VW'(0));
        check("R1 done", VW'(done), VW'(0));
        check("R1 wb_valid", VW'(wb_valid), VW'(0));
        rst_n = 1'b1;

        // access while disabled is ignored
        access(14'd0, 6'd0, bcast(16'h3c00));
        check("R2 disabled pc", VW'(pc), VW'(0));
        check("R2 disabled wb", VW'(wb_valid), VW'(0));

        // table of lane arithmetic: MOV g0<-bank(b); op g1 = bank(a) op g0; EXIT
        for (int i = 0; i < 12; i++) begin
            en = 1'b0;
            load(5'd0, 32'h3000_4000);
            load(5'd1, (VECS[i][63:48] == 16'd1) ? 32'h1100_4000 : 32'h2100_4000);
            load(5'd2, 32'h7000_0000);
            en = 1'b1;
            access(14'd0, 6'd0, bcast(VECS[i][31:16]));
            access(14'd0, 6'd0, bcast(VECS[i][47:32]));
            check((VECS[i][63:48] == 16'd1) ? "R4 R10 add" : "R5 R10 mul",
                  wb_data, bcast(VECS[i][15:0]));
            access(14'd0, 6'd0, '0);
        end
        check("R9 done after exit", VW'(done), VW'(1));

        // load while enabled is dropped
        en = 1'b0;
        load(5'd0, 32'h3000_4000);
        load(5'd1, 32'h1100_4000);
        load(5'd2, 32'h7000_0000);
        check("R9 load clears done", VW'(done), VW'(0));
        en = 1'b1;
        load(5'd0, 32'h7000_0000);
        access(14'd0, 6'd0, bcast(16'h3c00));
        check("R3 ignored load wb", VW'(wb_valid), VW'(1));
        check("R3 ignored load pc", VW'(pc), VW'(1));
        check("R3 ignored load done", VW'(done), VW'(0));
        access(14'd0, 6'd0, bcast(16'h3c00));
        check("R2 pc step", VW'(pc), VW'(2));
        access(14'd0, 6'd0, '0);

        // scalar operand broadcast
        en = 1'b0;
        load(5'd0, 32'h4300_0000);
        load(5'd1, 32'h1203_6000);
        load(5'd2, 32'h7000_0000);
        en = 1'b1;
        access(14'd0, 6'd0, {240'h0, 16'h4000});
        access(14'd0, 6'd0, bcast(16'h3c00));
        check("R6 scalar broadcast", wb_data, bcast(16'h4200));
        access(14'd0, 6'd0, '0);

        // address-aligned indices: g13 and s5 come from row/col
        en = 1'b0;
        load(5'd0, 32'h4500_0000);
        load(5'd1, 32'h3000_c000);
        load(5'd2, 32'h1000_a000);
        load(5'd3, 32'h7000_0000);
        en = 1'b1;
        access(14'd0, 6'd0, {240'h0, 16'h3c00});
        access(14'd1, 6'd5, bcast(16'h4400));
        access(14'd1, 6'd45, bcast(16'h0000));
        check("R7 aligned add", wb_data, bcast(16'h4500));
        access(14'd0, 6'd0, '0);

        // counted jump: MOV, JUMP to 0 twice, EXIT
        en = 1'b0;
        load(5'd0, 32'h3000_4000);
        load(5'd1, 32'h6000_0200);
        load(5'd2, 32'h7000_0000);
        en = 1'b1;
        begin
            logic [4:0] exp_pc [7] = '{5'd1, 5'd0, 5'd1, 5'd0, 5'd1, 5'd2, 5'd0};
            for (int k = 0; k < 7; k++) begin
                access(14'd0, 6'd0, bcast(16'h3c00));
                check("R8 jump pc", VW'(pc), VW'(exp_pc[k]));
            end
        end
        check("R9 exit done", VW'(done), VW'(1));

        // reset mid-program
        access(14'd0, 6'd0, bcast(16'h3c00));
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset pc", VW'(pc), VW'(0));
        check("R1 reset done", VW'(done), VW'(0));
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule